// File: doc/BRIEF.md
# Cascaded Serial-Bus Clock Divider

This block derives a slow serial-bus clock from a fast parent clock by passing the parent rate through four counting stages in a fixed order. The first stage is a prescaler whose ratio is fixed at build time. The second always divides by ten and cannot be skipped. The third divides by a power of two chosen at run time. The fourth divides by a run-time integer plus a build-time offset. Each stage is a counter that passes a one-cycle enable to the next stage. The last stage produces the block's outputs: a one-cycle pulse stream, and a level that flips on every pulse.

Both run-time factors live in one seven-bit control word that is written over a simple write strobe and can always be read back. A new word is held in a shadow copy. It is moved into the active divisor only when the last stage reaches terminal count, so a divisor change never cuts a period short or stretches one in a way that makes a runt pulse. Software works out the two factors. This block only applies them.

Top module: `serial_clk_divider`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `div_en`, `div_clk` and `rd_data` are all 0.
- R2: In the cycle after a clock edge with `wr_en` high, `rd_data` equals the `wr_data` sampled at that edge. Bits [6:3] hold the multiplier field M (0..15) and bits [2:0] hold the shift field N (0..7).
- R3: Once a configuration is active, consecutive `div_en` pulses are exactly PRE_DIV * 10 * 2^N * (M + M_OFFSET) clock cycles apart.
- R4: `div_en` is never high for two cycles in a row.
- R5: `div_clk` changes value in exactly those cycles in which `div_en` is high, and holds its value in all other cycles.
- R6: A new control word takes effect only at the next terminal count of the last stage. The interval already running when the word is written completes with the old divisor, and the interval that follows uses the new one.
- R7: The extreme settings divide correctly: M=0 with N=0 gives the smallest interval, N=7 gives a 128-fold shift, M=15 gives a factor of 15 + M_OFFSET, and M=15 with N=7 gives the largest interval.
- R8: Reset loads M=0 and N=0 and clears every counter, so the first `div_en` after reset is released comes exactly PRE_DIV * 10 * M_OFFSET cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 7 | Control word to write: M in [6:3], N in [2:0] |
| rd_data | output | 7 | Readback of the most recently written control word |
| div_en | output | 1 | One-cycle enable pulse, one per divided interval |
| div_clk | output | 1 | Divided level that flips on every `div_en` pulse |

## Verification
Readback is due one cycle after the write edge. The bench samples it at the following falling edge. A pulse interval is due exactly PRE_DIV * 10 * 2^N * (M + M_OFFSET) cycles after the previous pulse. The bench synchronises on one pulse at a falling edge and then counts falling edges until the next pulse is seen, so the count equals the divisor with no off-by-one slack. Because the divisor is applied late, the bench waits for the pulse that loads a new word before it starts counting. The deferral test counts the interval that was open at the write separately from the one after it. The first pulse after reset is counted from the first edge with reset low.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int M_W   = 4;
    localparam int N_W   = 3;
    localparam int CFG_W = M_W + N_W;

    // field order is significant: M occupies [6:3], N occupies [2:0]
    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } cfg_t;
endpackage

// File: rtl/div_stage.sv
module div_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_in,
    input  logic [W-1:0] limit,
    output logic         tc
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tc    = en_in && (cnt_q == limit);
        if (en_in) begin
            if (cnt_q == limit) cnt_d = '0;
            else                cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/serial_clk_divider.sv
module serial_clk_divider
    import clkdiv_pkg::*;
#(
    parameter int PRE_DIV  = 2,
    parameter int M_OFFSET = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output logic             div_en,
    output logic             div_clk
);
    localparam int W1 = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam int W2 = 4;
    localparam int W3 = (2 ** N_W) - 1;
    localparam int W4 = $clog2((2 ** M_W) + M_OFFSET);

    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
        logic en;
        logic lvl;
    } state_t;

    state_t s_d, s_q;
    logic tc1, tc2, tc3, tc4;
    logic [W3-1:0] lim3;
    logic [W4-1:0] lim4;

    generate
        if (PRE_DIV == 1) begin : g_nopre
            assign tc1 = 1'b1;
        end else begin : g_pre
            div_stage #(.W(W1)) u_pre (
                .clk  (clk),
                .rst  (rst),
                .en_in(1'b1),
                .limit(W1'(PRE_DIV - 1)),
                .tc   (tc1)
            );
        end
    endgenerate

    div_stage #(.W(W2)) u_ten (
        .clk  (clk),
        .rst  (rst),
        .en_in(tc1),
        .limit(W2'(9)),
        .tc   (tc2)
    );

    always_comb begin
        lim3 = '0;
        for (int i = 0; i < W3; i++) begin
            if (i < int'(s_q.active.n)) lim3[i] = 1'b1;
        end
        lim4 = W4'(s_q.active.m) + W4'(M_OFFSET - 1);
    end

    div_stage #(.W(W3)) u_pow2 (
        .clk  (clk),
        .rst  (rst),
        .en_in(tc2),
        .limit(lim3),
        .tc   (tc3)
    );

    div_stage #(.W(W4)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .en_in(tc3),
        .limit(lim4),
        .tc   (tc4)
    );

    always_comb begin
        s_d    = s_q;
        s_d.en = 1'b0;
        if (wr_en) s_d.shadow = cfg_t'(wr_data);
        if (tc4) begin
            s_d.active = s_q.shadow;
            s_d.en     = 1'b1;
            s_d.lvl    = ~s_q.lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rd_data = s_q.shadow;
    assign div_en  = s_q.en;
    assign div_clk = s_q.lvl;
endmodule

// File: rtl/serial_clk_divider_chk.sv
module serial_clk_divider_chk
    import clkdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [CFG_W-1:0] wr_data,
    input logic [CFG_W-1:0] rd_data,
    input logic             div_en,
    input logic             div_clk
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!div_en && !div_clk && rd_data == '0));

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) && !$past(rst) |-> rd_data == $past(wr_data));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        div_en |=> !div_en);

    // R5
    toggle_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        div_en |-> div_clk != $past(div_clk));

    // R5
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !div_en |-> $stable(div_clk));
endmodule

bind serial_clk_divider serial_clk_divider_chk u_chk (.*);

// File: tb/tb_serial_clk_divider.sv
module tb_serial_clk_divider;
    localparam int PRE = 2;
    localparam int OFF = 1;
    localparam int MAXWAIT = 50000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic [6:0] rd_data;
    logic       div_en;
    logic       div_clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_clk_divider #(.PRE_DIV(PRE), .M_OFFSET(OFF)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .div_en(div_en), .div_clk(div_clk)
    );

    function automatic int exp_div(input int m, input int n);
        return PRE * 10 * (1 << n) * (m + OFF);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int m, input int n);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = {4'(m), 3'(n)};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync_pulse();
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!div_en && k < MAXWAIT);
        if (!div_en) check("R3 pulse timeout", 0, 1);
    endtask

    // counts cycles to the next pulse; checks R4 and R5 along the way
    task automatic count_interval(output int cnt);
        logic lvl = div_clk;
        bit held = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            cnt++;
            if (cnt == 1) check("R4 pulse width", int'(div_en), 0);
            if (!div_en && div_clk != lvl) held = 1'b0;
        end while (!div_en && cnt < MAXWAIT);
        check("R5 level held between pulses", int'(held), 1);
        check("R5 level flips on pulse", int'(div_clk), int'(!lvl));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 div_en in reset", int'(div_en), 0);
        check("R1 div_clk in reset", int'(div_clk), 0);
        check("R1 rd_data in reset", int'(rd_data), 0);
    endtask

    task automatic t_first_pulse();
        int cnt = 0;
        rst = 1'b0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!div_en && cnt < MAXWAIT);
        check("R8 first pulse after reset", cnt, exp_div(0, 0));
    endtask

    task automatic t_readback();
        write_cfg(9, 5);
        check("R2 readback", int'(rd_data), (9 << 3) | 5);
        write_cfg(0, 0);
        check("R2 readback zero", int'(rd_data), 0);
    endtask

    task automatic t_interval(input int m, input int n, input string req);
        int cnt;
        write_cfg(m, n);
        sync_pulse();
        count_interval(cnt);
        check(req, cnt, exp_div(m, n));
    endtask

    task automatic t_deferred();
        int cnt;
        write_cfg(1, 0);
        sync_pulse();
        sync_pulse();
        wr_en = 1'b1;
        wr_data = {4'(3), 3'(0)};
        count_interval(cnt);
        check("R6 open interval keeps old divisor", cnt, exp_div(1, 0));
        count_interval(cnt);
        check("R6 next interval uses new divisor", cnt, exp_div(3, 0));
    endtask

    task automatic t_reset_reloads();
        write_cfg(7, 2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 rd_data cleared by reset", int'(rd_data), 0);
        t_first_pulse();
    endtask

    initial begin
        t_reset();
        t_first_pulse();
        t_readback();
        t_interval(0, 0, "R3 M=0 N=0");
        t_interval(5, 2, "R3 M=5 N=2");
        t_interval(2, 3, "R3 M=2 N=3");
        t_interval(15, 0, "R7 M=15");
        t_interval(0, 7, "R7 N=7");
        t_interval(15, 7, "R7 M=15 N=7");
        t_interval(0, 0, "R7 back to minimum");
        t_deferred();
        t_reset_reloads();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected completion", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule